// File: doc/BRIEF.md
# Half-Precision Floating-Point Instruction Decoder

This block is a purely combinational decoder for the 16-bit floating-point operation group of a 32-bit instruction stream. It takes one instruction word and returns three things: a numeric operation code, the register index fields and the rounding-mode field. It also returns a valid flag that is high only when the word is a supported half-precision operation under the current configuration.

Three configuration inputs set which encodings are accepted:

- **Dedicated-register enable.** Operands live in a separate floating-point register file.
- **Shared-register enable.** Operands live in the integer register file.
- **64-bit flag.** The integer registers are 64 bits wide.

Half-precision decode is active when either enable is high. The two register moves need the dedicated-register enable. The 64-bit integer conversions need the 64-bit flag.

The block does not execute operations, resolve the dynamic rounding mode, or decode loads and stores.

Top module: `hfp_decoder`

## Requirements
- R1: When both enables are low, valid is 0 and the operation code is 0 for every instruction word.
- R2: With major opcode 1010011, funct7 (bits 31:25) values 0000010, 0000110, 0001010 and 0001110 decode as add (code 1), subtract (2), multiply (3) and divide (4), with either enable alone.
- R3: Opcodes 1000011, 1000111, 1001011 and 1001111 decode as madd (5), msub (6), nmsub (7) and nmadd (8) only when bits 26:25 equal 10. Any other value in those bits is invalid.
- R4: With funct7 0010010, funct3 (bits 14:12) values 000/001/010 give sign-inject plain (9), negated (10) and xor (11). With funct7 0010110, funct3 000/001 give min (12) and max (13). Other funct3 values are invalid.
- R5: With funct7 1010010, funct3 010/001/000 give equal (14), less-than (15) and less-or-equal (16). Funct3 011 is invalid.
- R6: Funct7 0101110 is square root (17) only when bits 24:20 are 00000.
- R7: Funct7 1100010 with bits 24:20 of 00000/00001 gives half-to-signed-32 (18) and half-to-unsigned-32 (19). Funct7 1101010 with the same values gives signed-32-to-half (22) and unsigned-32-to-half (23). These decode regardless of the 64-bit flag.
- R8: Bits 24:20 values 00010/00011 under those two funct7 values give half-to-signed-64 (20), half-to-unsigned-64 (21), signed-64-to-half (24) and unsigned-64-to-half (25), but only when the 64-bit flag is 1.
- R9: The following format conversions decode; any other bits 24:20 value under these funct7 values is invalid:
  - Funct7 0100010 with bits 24:20 = 00000 is single-to-half (26).
  - Funct7 0100010 with bits 24:20 = 00001 is double-to-half (27).
  - Funct7 0100000 with bits 24:20 = 00010 is half-to-single (28).
  - Funct7 0100001 with bits 24:20 = 00010 is half-to-double (29).
- R10: With bits 24:20 = 00000, the following decode:
  - Funct7 1110010 with funct3 001 is classify (30) and decodes with either enable.
  - Funct7 1110010 with funct3 000 is move-to-integer (31).
  - Funct7 1111010 with funct3 000 is move-from-integer (32).
  - Both moves decode only when the dedicated-register enable is 1.
- R11: For operations that carry a rounding mode (codes 1-8 and 17-29), a bits 14:12 value of 101 or 110 makes the word invalid. The value 111 (dynamic) is accepted and passed through unchanged.
- R12: The field outputs are always the raw slices of the word, whatever the valid flag: rd = 11:7, rs1 = 19:15, rs2 = 24:20, rs3 = 31:27, rounding mode = 14:12.
- R13: Any word that is not decoded, including one with an unrelated major opcode, gives valid 0 and operation code 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word |
| fpreg_en_i | input | 1 | Half decode with dedicated floating-point registers |
| intreg_en_i | input | 1 | Half decode with operands in integer registers |
| xlen64_i | input | 1 | Integer registers are 64 bits wide |
| valid_o | output | 1 | Word is a supported half-precision operation |
| op_o | output | 6 | Operation code (0 when invalid) |
| rd_o | output | 5 | Destination index |
| rs1_o | output | 5 | First source index |
| rs2_o | output | 5 | Second source index |
| rs3_o | output | 5 | Third source index |
| rm_o | output | 3 | Rounding-mode field |

## Verification
The hardest cases to reach are those where a single configuration bit or field value flips validity while the rest of the word is unchanged. Examples are a 64-bit conversion with the 64-bit flag low, a register move under the shared-register enable alone, and a rounding-mode operation carrying a reserved mode. The stimulus builds each word from its fields and presents it twice or more: once in the legal setting and again with only the gating bit or field changed. That way, a decoder that ignores the gate shows a difference at the ports.

// File: rtl/hfp_dec_pkg.sv
package hfp_dec_pkg;

    localparam int INSTR_W = 32;
    localparam int IDX_W   = 5;
    localparam int RM_W    = 3;
    localparam int OP_W    = 6;

    localparam logic [6:0] OPC_FP   = 7'b1010011;
    localparam logic [6:0] OPC_MADD = 7'b1000011;
    localparam logic [6:0] OPC_MSUB = 7'b1000111;
    localparam logic [6:0] OPC_NMSB = 7'b1001011;
    localparam logic [6:0] OPC_NMAD = 7'b1001111;
    localparam logic [1:0] FMT_HALF = 2'b10;

    typedef enum logic [OP_W-1:0] {
        HOP_NONE    = 6'd0,
        HOP_ADD     = 6'd1,
        HOP_SUB     = 6'd2,
        HOP_MUL     = 6'd3,
        HOP_DIV     = 6'd4,
        HOP_MADD    = 6'd5,
        HOP_MSUB    = 6'd6,
        HOP_NMSUB   = 6'd7,
        HOP_NMADD   = 6'd8,
        HOP_SGNJ    = 6'd9,
        HOP_SGNJN   = 6'd10,
        HOP_SGNJX   = 6'd11,
        HOP_MIN     = 6'd12,
        HOP_MAX     = 6'd13,
        HOP_EQ      = 6'd14,
        HOP_LT      = 6'd15,
        HOP_LE      = 6'd16,
        HOP_SQRT    = 6'd17,
        HOP_H2W     = 6'd18,
        HOP_H2WU    = 6'd19,
        HOP_H2L     = 6'd20,
        HOP_H2LU    = 6'd21,
        HOP_W2H     = 6'd22,
        HOP_WU2H    = 6'd23,
        HOP_L2H     = 6'd24,
        HOP_LU2H    = 6'd25,
        HOP_S2H     = 6'd26,
        HOP_D2H     = 6'd27,
        HOP_H2S     = 6'd28,
        HOP_H2D     = 6'd29,
        HOP_CLASS   = 6'd30,
        HOP_MV2INT  = 6'd31,
        HOP_MVFRINT = 6'd32
    } hop_e;

    typedef struct packed {
        logic [IDX_W-1:0] rs3;
        logic [1:0]       fmt;
        logic [IDX_W-1:0] rs2;
        logic [IDX_W-1:0] rs1;
        logic [RM_W-1:0]  funct3;
        logic [IDX_W-1:0] rd;
        logic [6:0]       opc;
    } hfp_fields_t;

    function automatic logic rm_reserved(input logic [RM_W-1:0] rm);
        return (rm == 3'b101) || (rm == 3'b110);
    endfunction

    function automatic logic op_takes_rm(input hop_e op);
        return ((op >= HOP_ADD) && (op <= HOP_NMADD)) ||
               ((op >= HOP_SQRT) && (op <= HOP_H2D));
    endfunction

endpackage

// File: rtl/hfp_fields.sv
module hfp_fields
    import hfp_dec_pkg::*;
(
    input  logic [INSTR_W-1:0] instr_i,
    output hfp_fields_t        fields_o
);
    assign fields_o = hfp_fields_t'(instr_i);
endmodule

// File: rtl/hfp_opmatch.sv
module hfp_opmatch
    import hfp_dec_pkg::*;
(
    input  logic [6:0]       opc_i,
    input  logic [6:0]       funct7_i,
    input  logic [IDX_W-1:0] rs2_i,
    input  logic [RM_W-1:0]  funct3_i,
    input  logic             xlen64_i,
    input  logic             fpreg_en_i,
    output hop_e             op_o
);
    logic rs2_zero;
    logic rs2_int_sel;
    assign rs2_zero    = (rs2_i == '0);
    assign rs2_int_sel = (rs2_i[IDX_W-1:2] == '0);

    always_comb begin
        op_o = HOP_NONE;
        unique case (opc_i)
            OPC_MADD: if (funct7_i[1:0] == FMT_HALF) op_o = HOP_MADD;
            OPC_MSUB: if (funct7_i[1:0] == FMT_HALF) op_o = HOP_MSUB;
            OPC_NMSB: if (funct7_i[1:0] == FMT_HALF) op_o = HOP_NMSUB;
            OPC_NMAD: if (funct7_i[1:0] == FMT_HALF) op_o = HOP_NMADD;
            OPC_FP: begin
                case (funct7_i)
                    7'b0000010: op_o = HOP_ADD;
                    7'b0000110: op_o = HOP_SUB;
                    7'b0001010: op_o = HOP_MUL;
                    7'b0001110: op_o = HOP_DIV;
                    7'b0010010: begin
                        case (funct3_i)
                            3'b000:  op_o = HOP_SGNJ;
                            3'b001:  op_o = HOP_SGNJN;
                            3'b010:  op_o = HOP_SGNJX;
                            default: op_o = HOP_NONE;
                        endcase
                    end
                    7'b0010110: begin
                        case (funct3_i)
                            3'b000:  op_o = HOP_MIN;
                            3'b001:  op_o = HOP_MAX;
                            default: op_o = HOP_NONE;
                        endcase
                    end
                    7'b1010010: begin
                        case (funct3_i)
                            3'b010:  op_o = HOP_EQ;
                            3'b001:  op_o = HOP_LT;
                            3'b000:  op_o = HOP_LE;
                            default: op_o = HOP_NONE;
                        endcase
                    end
                    7'b0101110: if (rs2_zero) op_o = HOP_SQRT;
                    7'b1100010: begin
                        if (rs2_int_sel) begin
                            case (rs2_i[1:0])
                                2'd0: op_o = HOP_H2W;
                                2'd1: op_o = HOP_H2WU;
                                2'd2: op_o = xlen64_i ? HOP_H2L  : HOP_NONE;
                                default: op_o = xlen64_i ? HOP_H2LU : HOP_NONE;
                            endcase
                        end
                    end
                    7'b1101010: begin
                        if (rs2_int_sel) begin
                            case (rs2_i[1:0])
                                2'd0: op_o = HOP_W2H;
                                2'd1: op_o = HOP_WU2H;
                                2'd2: op_o = xlen64_i ? HOP_L2H  : HOP_NONE;
                                default: op_o = xlen64_i ? HOP_LU2H : HOP_NONE;
                            endcase
                        end
                    end
                    7'b0100010: begin
                        if (rs2_i == 5'd0) op_o = HOP_S2H;
                        else if (rs2_i == 5'd1) op_o = HOP_D2H;
                    end
                    7'b0100000: if (rs2_i == 5'd2) op_o = HOP_H2S;
                    7'b0100001: if (rs2_i == 5'd2) op_o = HOP_H2D;
                    7'b1110010: begin
                        if (rs2_zero && funct3_i == 3'b001) op_o = HOP_CLASS;
                        else if (rs2_zero && funct3_i == 3'b000 && fpreg_en_i)
                            op_o = HOP_MV2INT;
                    end
                    7'b1111010: begin
                        if (rs2_zero && funct3_i == 3'b000 && fpreg_en_i)
                            op_o = HOP_MVFRINT;
                    end
                    default: op_o = HOP_NONE;
                endcase
            end
            default: op_o = HOP_NONE;
        endcase
    end

    always_comb begin
        if ((op_o == HOP_MV2INT) || (op_o == HOP_MVFRINT))
            assert_move_needs_fpreg_R10: assert (fpreg_en_i);
        if ((op_o == HOP_H2L) || (op_o == HOP_H2LU) || (op_o == HOP_L2H) || (op_o == HOP_LU2H))
            assert_wide_cvt_needs_x64_R8: assert (xlen64_i);
    end
endmodule

// File: rtl/hfp_rmgate.sv
module hfp_rmgate
    import hfp_dec_pkg::*;
(
    input  hop_e            op_raw_i,
    input  logic [RM_W-1:0] rm_i,
    input  logic            any_en_i,
    output logic            valid_o,
    output hop_e            op_o
);
    logic rm_bad;
    assign rm_bad  = op_takes_rm(op_raw_i) && rm_reserved(rm_i);
    assign valid_o = any_en_i && (op_raw_i != HOP_NONE) && !rm_bad;
    assign op_o    = valid_o ? op_raw_i : HOP_NONE;
endmodule

// File: rtl/hfp_decoder.sv
module hfp_decoder
    import hfp_dec_pkg::*;
(
    input  logic [31:0] instr_i,
    input  logic        fpreg_en_i,
    input  logic        intreg_en_i,
    input  logic        xlen64_i,
    output logic        valid_o,
    output logic [5:0]  op_o,
    output logic [4:0]  rd_o,
    output logic [4:0]  rs1_o,
    output logic [4:0]  rs2_o,
    output logic [4:0]  rs3_o,
    output logic [2:0]  rm_o
);
    hfp_fields_t fld;
    hop_e        op_raw;
    hop_e        op_fin;
    logic        any_en;

    assign any_en = fpreg_en_i | intreg_en_i;

    hfp_fields u_fields (
        .instr_i  (instr_i),
        .fields_o (fld)
    );

    hfp_opmatch u_match (
        .opc_i      (fld.opc),
        .funct7_i   ({fld.rs3, fld.fmt}),
        .rs2_i      (fld.rs2),
        .funct3_i   (fld.funct3),
        .xlen64_i   (xlen64_i),
        .fpreg_en_i (fpreg_en_i),
        .op_o       (op_raw)
    );

    hfp_rmgate u_rm (
        .op_raw_i (op_raw),
        .rm_i     (fld.funct3),
        .any_en_i (any_en),
        .valid_o  (valid_o),
        .op_o     (op_fin)
    );

    assign op_o  = op_fin;
    assign rd_o  = fld.rd;
    assign rs1_o = fld.rs1;
    assign rs2_o = fld.rs2;
    assign rs3_o = fld.rs3;
    assign rm_o  = fld.funct3;

    always_comb begin
        if (valid_o == 1'b1) begin
            assert_valid_needs_enable_R1: assert (fpreg_en_i || intreg_en_i);
            assert_valid_has_op_R13: assert (op_o != 6'd0);
            if (op_takes_rm(op_fin))
                assert_no_reserved_rm_R11: assert (rm_o != 3'b101 && rm_o != 3'b110);
        end
        if (valid_o == 1'b0)
            assert_invalid_op_zero_R13: assert (op_o == 6'd0);
    end
endmodule

// File: tb/hfp_decoder_bench.sv
module hfp_decoder_bench;
    logic        clk = 1'b0;
    logic [31:0] instr;
    logic        fp_en, int_en, x64;
    logic        valid;
    logic [5:0]  op;
    logic [4:0]  rd, rs1, rs2, rs3;
    logic [2:0]  rm;
    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    hfp_decoder u_hfp_decoder (
        .instr_i(instr), .fpreg_en_i(fp_en), .intreg_en_i(int_en), .xlen64_i(x64),
        .valid_o(valid), .op_o(op), .rd_o(rd), .rs1_o(rs1), .rs2_o(rs2),
        .rs3_o(rs3), .rm_o(rm)
    );

    localparam logic [6:0] FP = 7'b1010011;

    function automatic logic [31:0] rt(input logic [6:0] f7, input logic [4:0] r2,
                                       input logic [2:0] f3);
        return {f7, r2, 5'd3, f3, 5'd4, FP};
    endfunction

    function automatic logic [31:0] ft(input logic [6:0] opc, input logic [1:0] fmt,
                                       input logic [2:0] f3);
        return {5'd9, fmt, 5'd2, 5'd3, f3, 5'd4, opc};
    endfunction

    task automatic apply(input logic [31:0] w, input logic f, input logic i, input logic x);
        @(negedge clk);
        instr = w; fp_en = f; int_en = i; x64 = x;
        #1;
    endtask

    task automatic chk(input string tag, input logic ev, input logic [5:0] eop);
        checks++;
        if (valid !== ev || op !== eop) begin
            fails++;
            $display("FAIL %s instr=%h got valid=%b op=%0d expected valid=%b op=%0d",
                     tag, instr, valid, op, ev, eop);
        end
    endtask

    task automatic t_disabled;
        apply(rt(7'b0000010, 5'd2, 3'b000), 1'b0, 1'b0, 1'b1); chk("R1 add disabled", 0, 0);
        apply(ft(7'b1000011, 2'b10, 3'b000), 1'b0, 1'b0, 1'b1); chk("R1 madd disabled", 0, 0);
    endtask

    task automatic t_arith;
        apply(rt(7'b0000010, 5'd2, 3'b000), 1'b1, 1'b0, 1'b0); chk("R2 add fp", 1, 1);
        apply(rt(7'b0000110, 5'd2, 3'b001), 1'b0, 1'b1, 1'b0); chk("R2 sub int", 1, 2);
        apply(rt(7'b0001010, 5'd2, 3'b010), 1'b0, 1'b1, 1'b0); chk("R2 mul", 1, 3);
        apply(rt(7'b0001110, 5'd2, 3'b011), 1'b1, 1'b0, 1'b0); chk("R2 div", 1, 4);
    endtask

    task automatic t_fma;
        apply(ft(7'b1000011, 2'b10, 3'b000), 1'b1, 1'b0, 1'b0); chk("R3 madd", 1, 5);
        apply(ft(7'b1000111, 2'b10, 3'b000), 1'b0, 1'b1, 1'b0); chk("R3 msub", 1, 6);
        apply(ft(7'b1001011, 2'b10, 3'b000), 1'b1, 1'b0, 1'b0); chk("R3 nmsub", 1, 7);
        apply(ft(7'b1001111, 2'b10, 3'b000), 1'b1, 1'b0, 1'b0); chk("R3 nmadd", 1, 8);
        apply(ft(7'b1000011, 2'b00, 3'b000), 1'b1, 1'b0, 1'b0); chk("R3 fmt 00", 0, 0);
        apply(ft(7'b1000011, 2'b01, 3'b000), 1'b1, 1'b0, 1'b0); chk("R3 fmt 01", 0, 0);
    endtask

    task automatic t_sgnj_minmax;
        apply(rt(7'b0010010, 5'd2, 3'b000), 1'b1, 1'b0, 1'b0); chk("R4 sgnj", 1, 9);
        apply(rt(7'b0010010, 5'd2, 3'b001), 1'b1, 1'b0, 1'b0); chk("R4 sgnjn", 1, 10);
        apply(rt(7'b0010010, 5'd2, 3'b010), 1'b0, 1'b1, 1'b0); chk("R4 sgnjx", 1, 11);
        apply(rt(7'b0010010, 5'd2, 3'b011), 1'b1, 1'b0, 1'b0); chk("R4 sgnj f3=3", 0, 0);
        apply(rt(7'b0010110, 5'd2, 3'b000), 1'b1, 1'b0, 1'b0); chk("R4 min", 1, 12);
        apply(rt(7'b0010110, 5'd2, 3'b001), 1'b1, 1'b0, 1'b0); chk("R4 max", 1, 13);
        apply(rt(7'b0010110, 5'd2, 3'b010), 1'b1, 1'b0, 1'b0); chk("R4 minmax f3=2", 0, 0);
        apply(rt(7'b0010010, 5'd2, 3'b101), 1'b1, 1'b0, 1'b0); chk("R4 f3=5", 0, 0);
    endtask

    task automatic t_cmp;
        apply(rt(7'b1010010, 5'd2, 3'b010), 1'b1, 1'b0, 1'b0); chk("R5 eq", 1, 14);
        apply(rt(7'b1010010, 5'd2, 3'b001), 1'b0, 1'b1, 1'b0); chk("R5 lt", 1, 15);
        apply(rt(7'b1010010, 5'd2, 3'b000), 1'b1, 1'b0, 1'b0); chk("R5 le", 1, 16);
        apply(rt(7'b1010010, 5'd2, 3'b011), 1'b1, 1'b0, 1'b0); chk("R5 f3=3", 0, 0);
    endtask

    task automatic t_sqrt;
        apply(rt(7'b0101110, 5'd0, 3'b000), 1'b1, 1'b0, 1'b0); chk("R6 sqrt", 1, 17);
        apply(rt(7'b0101110, 5'd1, 3'b000), 1'b1, 1'b0, 1'b0); chk("R6 sqrt rs2!=0", 0, 0);
    endtask

    task automatic t_int_cvt;
        apply(rt(7'b1100010, 5'd0, 3'b000), 1'b1, 1'b0, 1'b0); chk("R7 h2w", 1, 18);
        apply(rt(7'b1100010, 5'd1, 3'b000), 1'b0, 1'b1, 1'b0); chk("R7 h2wu", 1, 19);
        apply(rt(7'b1101010, 5'd0, 3'b000), 1'b1, 1'b0, 1'b1); chk("R7 w2h x64", 1, 22);
        apply(rt(7'b1101010, 5'd1, 3'b000), 1'b1, 1'b0, 1'b0); chk("R7 wu2h", 1, 23);
        apply(rt(7'b1100010, 5'd4, 3'b000), 1'b1, 1'b0, 1'b1); chk("R7 rs2=4", 0, 0);
    endtask

    task automatic t_cvt64;
        apply(rt(7'b1100010, 5'd2, 3'b000), 1'b1, 1'b0, 1'b1); chk("R8 h2l", 1, 20);
        apply(rt(7'b1100010, 5'd3, 3'b000), 1'b1, 1'b0, 1'b1); chk("R8 h2lu", 1, 21);
        apply(rt(7'b1101010, 5'd2, 3'b000), 1'b0, 1'b1, 1'b1); chk("R8 l2h", 1, 24);
        apply(rt(7'b1101010, 5'd3, 3'b000), 1'b1, 1'b0, 1'b1); chk("R8 lu2h", 1, 25);
        apply(rt(7'b1100010, 5'd2, 3'b000), 1'b1, 1'b0, 1'b0); chk("R8 h2l x32", 0, 0);
        apply(rt(7'b1101010, 5'd3, 3'b000), 1'b1, 1'b0, 1'b0); chk("R8 lu2h x32", 0, 0);
    endtask

    task automatic t_fmt_cvt;
        apply(rt(7'b0100010, 5'd0, 3'b000), 1'b1, 1'b0, 1'b0); chk("R9 s2h", 1, 26);
        apply(rt(7'b0100010, 5'd1, 3'b000), 1'b1, 1'b0, 1'b0); chk("R9 d2h", 1, 27);
        apply(rt(7'b0100000, 5'd2, 3'b000), 1'b0, 1'b1, 1'b0); chk("R9 h2s", 1, 28);
        apply(rt(7'b0100001, 5'd2, 3'b000), 1'b1, 1'b0, 1'b0); chk("R9 h2d", 1, 29);
        apply(rt(7'b0100010, 5'd2, 3'b000), 1'b1, 1'b0, 1'b0); chk("R9 bad src", 0, 0);
        apply(rt(7'b0100000, 5'd0, 3'b000), 1'b1, 1'b0, 1'b0); chk("R9 bad h2s", 0, 0);
    endtask

    task automatic t_class_mv;
        apply(rt(7'b1110010, 5'd0, 3'b001), 1'b1, 1'b0, 1'b0); chk("R10 class fp", 1, 30);
        apply(rt(7'b1110010, 5'd0, 3'b001), 1'b0, 1'b1, 1'b0); chk("R10 class int", 1, 30);
        apply(rt(7'b1110010, 5'd0, 3'b000), 1'b1, 1'b0, 1'b0); chk("R10 mv2int fp", 1, 31);
        apply(rt(7'b1110010, 5'd0, 3'b000), 1'b0, 1'b1, 1'b0); chk("R10 mv2int int", 0, 0);
        apply(rt(7'b1111010, 5'd0, 3'b000), 1'b1, 1'b0, 1'b0); chk("R10 mvfrint fp", 1, 32);
        apply(rt(7'b1111010, 5'd0, 3'b000), 1'b0, 1'b1, 1'b0); chk("R10 mvfrint int", 0, 0);
    endtask

    task automatic t_rm;
        apply(rt(7'b0000010, 5'd2, 3'b101), 1'b1, 1'b0, 1'b0); chk("R11 add rm101", 0, 0);
        apply(ft(7'b1001111, 2'b10, 3'b110), 1'b1, 1'b0, 1'b0); chk("R11 nmadd rm110", 0, 0);
        apply(rt(7'b0101110, 5'd0, 3'b110), 1'b1, 1'b0, 1'b0); chk("R11 sqrt rm110", 0, 0);
        apply(rt(7'b0001010, 5'd2, 3'b111), 1'b1, 1'b0, 1'b0); chk("R11 mul dyn", 1, 3);
        checks++;
        if (rm !== 3'b111) begin
            fails++; $display("FAIL R11 rm passthrough got %b expected 111", rm);
        end
    endtask

    task automatic t_fields;
        apply(32'b10110_10_01101_11001_100_00111_1000011, 1'b1, 1'b0, 1'b0);
        chk("R12 fma fields", 1, 5);
        checks++;
        if (rs3 !== 5'b10110 || rs2 !== 5'b01101 || rs1 !== 5'b11001 ||
            rm !== 3'b100 || rd !== 5'b00111) begin
            fails++;
            $display("FAIL R12 fields got %h %h %h %h %h expected 16 0d 19 4 07",
                     rs3, rs2, rs1, rm, rd);
        end
        apply(32'hFEDC_BA98, 1'b0, 1'b0, 1'b0);
        checks++;
        if (rd !== 5'b10101 || rs1 !== 5'b11001 || rs2 !== 5'b01101 ||
            rs3 !== 5'b11111 || rm !== 3'b011) begin
            fails++;
            $display("FAIL R12 invalid fields got %h %h %h %h %h expected 15 19 0d 1f 3",
                     rd, rs1, rs2, rs3, rm);
        end
    endtask

    task automatic t_other;
        apply(32'h0000_0013, 1'b1, 1'b1, 1'b1); chk("R13 other opcode", 0, 0);
        apply(rt(7'b0000000, 5'd2, 3'b000), 1'b1, 1'b0, 1'b0); chk("R13 single add", 0, 0);
        apply(rt(7'b1111111, 5'd0, 3'b000), 1'b1, 1'b1, 1'b1); chk("R13 unknown f7", 0, 0);
    endtask

    initial begin
        fork
            begin
                instr = '0; fp_en = 0; int_en = 0; x64 = 0;
                t_disabled();
                t_arith();
                t_fma();
                t_sgnj_minmax();
                t_cmp();
                t_sqrt();
                t_int_cvt();
                t_cvt64();
                t_fmt_cvt();
                t_class_mv();
                t_rm();
                t_fields();
                t_other();
            end
            begin
                while (cycles < 20000) begin
                    @(posedge clk); cycles++;
                end
                checks++; fails++;
                $display("FAIL watchdog expired got hang expected completion");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule